// File: doc/BRIEF.md
# Priority 2x2 Self-Routing Switch Element

This block is one switching element of a synchronous multistage fabric for fixed-length packets that are aligned to a common slot. Two one-bit serial streams come in, one with high priority and one with low priority, together with a shared slot strobe that marks the first bit of both packets. Each packet starts with a presence bit and carries one address bit for every stage of the fabric. An element at stage `STAGE` looks only at its own address bit to pick an output: 0 selects output A and 1 selects output B.

At each slot the element reads the presence bit of the high-priority packet and its own address bit from both streams. A small fixed gate network turns these into a bar/cross fabric setting and a contention flag. Both are held for the whole packet. The high-priority packet always gets its chosen output. When both packets want the same output, the low-priority packet is dropped for the full slot. Both data paths go through the same fixed delay, so the packets leave the element still aligned to the slot.

Top module: `swx_prio_switch`

## Requirements
- R1: The bit that arrives in the same cycle as the slot strobe is the presence bit. Address bit k arrives k+1 cycles after the strobe. This element routes on the bit at offset `STAGE`+1 only.
- R2: When the high-priority presence bit is 1 and its address bit is 0, the high-priority packet leaves on output A and `bar_o` reads 1.
- R3: When the high-priority presence bit is 1 and its address bit is 1, the high-priority packet leaves on output B and `bar_o` reads 0.
- R4: When the high-priority presence bit is 0, its address bit is treated as 0. The low-priority packet then goes to output A with `bar_o`=0 when its address bit is 0, and to output B with `bar_o`=1 when its address bit is 1.
- R5: `clash_o` is 1 exactly when the high-priority presence bit is 1 and the two address bits are equal. While it is 1, the low-priority packet is replaced by zeros on every output for the whole slot.
- R6: Every bit reaches its output exactly `STAGE`+2 cycles after it enters, and the delay is the same on both paths.
- R7: `bar_o` and `clash_o` change only in the cycle `STAGE`+2 after a slot strobe. They then hold for the whole packet.
- R8: The high-priority stream is forwarded only when its presence bit was 1. An output with no packet routed to it drives 0.
- R9: While reset is asserted, `bar_o`, `clash_o`, `out_a_o` and `out_b_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Slot strobe, high in the cycle of the first packet bit |
| hi_i | input | 1 | High-priority serial data |
| lo_i | input | 1 | Low-priority serial data |
| out_a_o | output | 1 | Output A serial data (address 0) |
| out_b_o | output | 1 | Output B serial data (address 1) |
| bar_o | output | 1 | Held fabric setting: 1 bar (hi to A, lo to B), 0 cross |
| clash_o | output | 1 | Held contention flag: low-priority packet dropped |

## Verification
The assertions assume that slot strobes are at least one packet length apart, so the label-sampling window of one slot never overlaps the next strobe. They also assume that both data inputs are 0 between packets. The stimulus keeps to this: slots are placed back to back or with short idle gaps, and only zeros are driven in those gaps. Inside a packet every bit may be random, including high-priority address bits whose presence bit is 0, because the element must ignore them.

// File: rtl/swx_pkg.sv
package swx_pkg;
  typedef struct packed {
    logic bar;   // 1: hi->A, lo->B
    logic drop;  // suppress lo stream
    logic live;  // hi stream carries a packet
  } fab_cfg_t;
endpackage

// File: rtl/swx_slot_ctl.sv
module swx_slot_ctl #(
  parameter int TAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  output logic smp_o
);
  localparam int CW = $clog2(TAP + 2);
  localparam logic [CW-1:0] TAP_C = CW'(TAP);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (slot_i) begin
      cnt_q <= CW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == TAP_C) run_q <= 1'b0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign smp_o = run_q && (cnt_q == TAP_C);

  // R1: exactly one label sample per slot
  a_r1_single_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_o && !slot_i) |=> !smp_o);
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TAP_C);
endmodule

// File: rtl/swx_route_logic.sv
module swx_route_logic (
  input  logic pres_i,
  input  logic ah_i,
  input  logic al_i,
  output logic scg_o,
  output logic crc_o
);
  logic ah_m, nor_pl, nor_hl;

  // absent hi packet: its address reads as 0
  assign ah_m   = ah_i & pres_i;
  assign nor_pl = ~(pres_i | al_i);
  assign nor_hl = ~(ah_m | al_i);
  assign scg_o  = ~(ah_m | nor_pl);
  assign crc_o  = (ah_m & al_i) | (pres_i & nor_hl);

  always_comb begin
    if (pres_i === 1'b1) begin
      a_r2_hi_served: assert (scg_o != ah_i);
    end
    if (crc_o === 1'b1) begin
      a_r5_clash_needs_hi: assert (pres_i);
    end
  end
endmodule

// File: rtl/swx_bit_delay.sv
module swx_bit_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] sh_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[DEPTH-1];
endmodule

// File: rtl/swx_prio_switch.sv
module swx_prio_switch
  import swx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int STAGE   = 1,
  parameter int PKT_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic out_a_o,
  output logic out_b_o,
  output logic bar_o,
  output logic clash_o
);
  localparam int TAP = STAGE + 1;  // address bit offset after strobe
  localparam int LAT = STAGE + 2;  // config valid from here on

  logic     id_q, smp, scg, crc, hi_d, lo_d, hi_g, lo_g;
  fab_cfg_t cfg_q;

  swx_slot_ctl #(.TAP(TAP)) u_ctl (
    .clk_i, .rst_ni, .slot_i, .smp_o(smp)
  );

  swx_route_logic u_route (
    .pres_i(id_q), .ah_i(hi_i), .al_i(lo_i), .scg_o(scg), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (slot_i) id_q <= hi_i;
      if (smp)    cfg_q <= '{bar: scg, drop: crc, live: id_q};
    end
  end

  swx_bit_delay #(.DEPTH(LAT)) u_dly_hi (
    .clk_i, .rst_ni, .d_i(hi_i), .q_o(hi_d)
  );
  swx_bit_delay #(.DEPTH(LAT)) u_dly_lo (
    .clk_i, .rst_ni, .d_i(lo_i), .q_o(lo_d)
  );

  assign hi_g    = hi_d & cfg_q.live;
  assign lo_g    = lo_d & ~cfg_q.drop;
  assign out_a_o = cfg_q.bar ? hi_g : lo_g;
  assign out_b_o = cfg_q.bar ? lo_g : hi_g;
  assign bar_o   = cfg_q.bar;
  assign clash_o = cfg_q.drop;

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp |=> $stable(cfg_q));
  a_r5_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |-> !(out_a_o && out_b_o));
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.live && !lo_d) |-> (!out_a_o && !out_b_o));
  a_r5_drop_has_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |-> cfg_q.live);
endmodule

// File: tb/swx_prio_switch_tb_top.sv
module swx_prio_switch_tb_top;
  localparam int ADDR_W  = 4;
  localparam int STAGE   = 2;
  localparam int PKT_LEN = 12;
  localparam int LAT     = STAGE + 2;
  localparam int NCYC    = 6000;
  localparam int NRST    = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, slot, hi, lo;
  logic out_a, out_b, bar, clash;

  swx_prio_switch #(.ADDR_W(ADDR_W), .STAGE(STAGE), .PKT_LEN(PKT_LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slot_i(slot), .hi_i(hi), .lo_i(lo),
    .out_a_o(out_a), .out_b_o(out_b), .bar_o(bar), .clash_o(clash)
  );

  bit st_slot [NCYC];
  bit st_hi   [NCYC];
  bit st_lo   [NCYC];
  bit ex_a    [NCYC];
  bit ex_b    [NCYC];
  bit ex_bar  [NCYC];
  bit ex_cl   [NCYC];
  bit ex_vld  [NCYC];
  int ex_tag  [NCYC];
  int errs = 0;
  int checks = 0;

  // R2: hi present, addr 0; R3: hi present, addr 1; R4/R8: hi absent; R5: clash
  function automatic string tag_s(int t);
    return $sformatf("R%0d", t);
  endfunction

  // R1: label bit for this stage sits at offset STAGE+1 after the strobe
  task automatic plan_slot(int c0, bit pih, bit ah, bit al);
    bit cl  = pih && (ah == al);
    bit dh  = ah;
    bit dl  = pih ? !ah : al;
    int tg  = cl ? 5 : (!pih ? 4 : (ah ? 3 : 2));
    st_slot[c0] = 1'b1;
    for (int j = 0; j < PKT_LEN; j++) begin
      bit hb, lb;
      int c = c0 + LAT + j;  // R6: fixed delay on both paths
      hb = (j == 0) ? pih : (j == STAGE + 1) ? ah : 1'($urandom);
      lb = (j == STAGE + 1) ? al : 1'($urandom);
      st_hi[c0+j] = hb;
      st_lo[c0+j] = lb;
      ex_a[c]   = (pih && !dh && hb) || (!cl && !dl && lb);
      ex_b[c]   = (pih &&  dh && hb) || (!cl &&  dl && lb);
      ex_vld[c] = 1'b1;
      ex_bar[c] = dl;
      ex_cl[c]  = cl;
      ex_tag[c] = tg;
    end
  endtask

  task automatic chk(bit ok, string tg, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", tg, what, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd4711));
    c = NRST + 2;
    // directed: all eight presence/address combinations, back to back
    for (int k = 0; k < 8; k++) begin
      plan_slot(c, k[2], k[1], k[0]);
      c += PKT_LEN;
    end
    // random slots with short idle gaps
    while (c + PKT_LEN + LAT + 8 < NCYC) begin
      c += $urandom_range(0, 3);
      plan_slot(c, 1'($urandom), 1'($urandom), 1'($urandom));
      c += PKT_LEN;
    end

    rst_n = 1'b0; slot = 1'b0; hi = 1'b0; lo = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      @(negedge clk);
      if (k == NRST) rst_n = 1'b1;
      slot = st_slot[k];
      hi   = st_hi[k];
      lo   = st_lo[k];
      #1;
      if (k < NRST) begin
        // R9: everything quiet in reset
        chk(!out_a && !out_b && !bar && !clash, "R9", "reset outputs",
            {out_a, out_b, bar, clash}, 0);
      end else begin
        string tg = ex_vld[k] ? tag_s(ex_tag[k]) : "R8";
        chk(out_a == ex_a[k], {tg, "/R6"}, "out_a", out_a, ex_a[k]);
        chk(out_b == ex_b[k], {tg, "/R6"}, "out_b", out_b, ex_b[k]);
        if (ex_vld[k]) begin
          // R7: held setting over the whole packet
          chk(bar == ex_bar[k], {tg, "/R7"}, "bar", bar, ex_bar[k]);
          chk(clash == ex_cl[k], {tg, "/R7"}, "clash", clash, ex_cl[k]);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule